// File: doc/BRIEF.md
# Line transmit framer and encoder

This block is the digital transmit side of a two-wire subscriber line transceiver. Once per 8 kHz frame it takes the bearer bits, the signalling bits and, at the higher rate, a housekeeping bit from parallel inputs. It puts an alternating frame-marker bit in front of them. A sync-relative prescrambler can optionally whiten the data so that it cannot imitate the marker pattern. A self-synchronizing scrambler whose polynomial depends on the link role always runs. The result is differentially encoded and then biphase encoded, and leaves the block as a serial stream of line symbols at twice the bit rate.

Two line rates are supported. The low rate carries 10 bits per frame and the high rate carries 20. The two ends of a link must use opposite roles, so that their scrambled streams stay uncorrelated. Each line symbol is held for a fixed number of clock cycles, set by a parameter for each rate. A one-cycle strobe marks each new symbol. A frame-start flag is raised together with the strobe of the first symbol of every frame. The analog filter that shapes the pulses sits downstream of this block.

Top module: `line_tx_framer`

## Requirements
- R1: With `rate_hi`=0 a frame is 20 symbols (10 bits). With `rate_hi`=1 it is 40 symbols (20 bits). `frame_start` is high only together with the `sym_stb` of the first symbol of a frame. All three outputs are 0 during reset.
- R2: Frame bit order is: the marker bit first, then the bearer bits MSB first, then D0 (`d_bits[0]`). The low rate uses `b_data[7:0]`. The high rate uses `b_data[15:0]`, followed by D1 (`d_bits[1]`) and then `hk`.
- R3: The marker bit is 1 in the first frame after reset and inverts in every later frame.
- R4: When `prescr_en`=1, each non-marker bit is XORed with bit 6 of a 7-bit LFSR (x^7+x^6+1; next state {q[5:0], q[6]^q[5]}). The LFSR is loaded with 7'h7F at every marker bit. The marker bit is never prescrambled. When `prescr_en`=0, the data passes through unchanged.
- R5: With `master`=1 the scrambler computes s[n] = x[n] ^ s[n-5] ^ s[n-23].
- R6: With `master`=0 the scrambler computes s[n] = x[n] ^ s[n-18] ^ s[n-23].
- R7: After reset the scrambler history is all ones. It advances on every frame bit, the marker bit included.
- R8: Differential encoding: e[n] = s[n] ^ e[n-1], with e[-1] = 0.
- R9: Biphase: each encoded bit e is sent as the symbol e followed by the symbol ~e.
- R10: The data inputs, `rate_hi`, `master` and `prescr_en` are sampled only at the start of a frame. Changes made during a frame have no effect until the next frame.
- R11: Symbols are spaced DIV_HI clock cycles apart at the high rate and DIV_LO cycles apart at the low rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_hi | input | 1 | 1 selects 20-bit frames, 0 selects 10-bit frames |
| master | input | 1 | 1 selects the master scrambler, 0 the slave scrambler |
| prescr_en | input | 1 | Enables the sync-relative prescrambler |
| b_data | input | 16 | Bearer bits for the next frame |
| d_bits | input | 2 | Signalling bits: [0] is D0, [1] is D1 |
| hk | input | 1 | Housekeeping bit (high rate only) |
| sym_out | output | 1 | Current line symbol |
| sym_stb | output | 1 | One-cycle pulse when `sym_out` takes a new symbol |
| frame_start | output | 1 | Pulses with `sym_stb` on the first symbol of a frame |

## Verification
The bench builds the block with DIV_HI=2 and DIV_LO=4. A 40-symbol frame therefore lasts only 80 cycles, and a run can cover many frames, including rate and role switches. This brings the 23-bit scrambler memory within reach: its reset-time all-ones history and its carry-over from frame to frame are both checked. The parity of the marker bit over many frames, and pairs of frames that change the input between frames or in the middle of a frame, are also covered.

// File: rtl/line_tx_framer.sv
module line_tx_framer #(
  parameter int DIV_HI = 32,
  parameter int DIV_LO = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rate_hi,
  input  logic        master,
  input  logic        prescr_en,
  input  logic [15:0] b_data,
  input  logic [1:0]  d_bits,
  input  logic        hk,
  output logic        sym_out,
  output logic        sym_stb,
  output logic        frame_start
);
  localparam int DW = (DIV_LO > DIV_HI) ? $clog2(DIV_LO + 1) : $clog2(DIV_HI + 1);
  localparam int SCR_LEN = 23;
  localparam int PRE_LEN = 7;
  localparam logic [PRE_LEN-1:0] PRE_SEED = '1;

  logic [DW-1:0]        div_q;
  logic                 half_q, rate_q, ms_q, pe_q, sync_q, dif_q;
  logic [4:0]           idx_q;
  logic [18:0]          word_q;
  logic [PRE_LEN-1:0]   pre_q;
  logic [SCR_LEN-1:0]   scr_q;

  logic [DW-1:0] div_last;
  logic          tick, start, ms_sel, raw, tap, scr_bit, enc_bit;
  logic [4:0]    idx_last;
  logic [18:0]   word_ld;

  assign div_last = rate_q ? DW'(DIV_HI - 1) : DW'(DIV_LO - 1);
  assign tick     = (div_q == div_last);
  assign start    = tick && !half_q && (idx_q == 5'd0);
  assign idx_last = rate_q ? 5'd19 : 5'd9;
  assign ms_sel   = start ? master : ms_q;
  assign raw      = (idx_q == 5'd0) ? sync_q : (word_q[18] ^ (pe_q & pre_q[PRE_LEN-1]));
  assign tap      = ms_sel ? scr_q[4] : scr_q[17];
  assign scr_bit  = raw ^ tap ^ scr_q[SCR_LEN-1];
  assign enc_bit  = scr_bit ^ dif_q;
  assign word_ld  = rate_hi ? {b_data, d_bits[0], d_bits[1], hk}
                            : {b_data[7:0], d_bits[0], 10'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q       <= '0;
      half_q      <= 1'b0;
      idx_q       <= '0;
      rate_q      <= 1'b0;
      ms_q        <= 1'b0;
      pe_q        <= 1'b0;
      sync_q      <= 1'b1;
      dif_q       <= 1'b0;
      word_q      <= '0;
      pre_q       <= PRE_SEED;
      scr_q       <= '1;
      sym_out     <= 1'b0;
      sym_stb     <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      sym_stb     <= tick;
      frame_start <= start;
      div_q       <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!half_q) begin
          sym_out <= enc_bit;
          dif_q   <= enc_bit;
          scr_q   <= {scr_q[SCR_LEN-2:0], scr_bit};
          half_q  <= 1'b1;
          if (idx_q == 5'd0) begin
            rate_q <= rate_hi;
            ms_q   <= master;
            pe_q   <= prescr_en;
            word_q <= word_ld;
            pre_q  <= PRE_SEED;
            sync_q <= ~sync_q;
          end else begin
            word_q <= {word_q[17:0], 1'b0};
            pre_q  <= {pre_q[PRE_LEN-2:0], pre_q[6] ^ pre_q[5]};
          end
        end else begin
          sym_out <= ~dif_q;
          half_q  <= 1'b0;
          idx_q   <= (idx_q == idx_last) ? 5'd0 : idx_q + 5'd1;
        end
      end
    end
  end
endmodule

// File: rtl/line_tx_framer_chk.sv
module line_tx_framer_chk #(
  parameter int DIV_HI = 32,
  parameter int DIV_LO = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_out,
  input logic       sym_stb,
  input logic       frame_start,
  input logic       half_q,
  input logic       rate_q,
  input logic [4:0] idx_q
);
  logic [31:0] gap;
  logic        seen, last_sym;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap      <= '0;
      seen     <= 1'b0;
      last_sym <= 1'b0;
    end else begin
      gap <= sym_stb ? 32'd0 : gap + 32'd1;
      if (sym_stb) begin
        seen     <= 1'b1;
        last_sym <= sym_out;
      end
    end
  end

  a_r11_cadence: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && seen) |-> (gap == 32'(($past(rate_q) ? DIV_HI : DIV_LO) - 1)));

  a_r9_biphase_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !half_q) |-> (sym_out != last_sym));

  a_r1_start_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (sym_stb && half_q && idx_q == 5'd0));

  a_r10_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(rate_q));
endmodule

bind line_tx_framer line_tx_framer_chk #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_out(sym_out), .sym_stb(sym_stb),
  .frame_start(frame_start), .half_q(half_q), .rate_q(rate_q), .idx_q(idx_q)
);

// File: tb/line_tx_framer_test.sv
module line_tx_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_hi = 1'b0, master = 1'b1, prescr_en = 1'b0, hk = 1'b0;
  logic [15:0] b_data = '0;
  logic [1:0]  d_bits = '0;
  logic sym_out, sym_stb, frame_start;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  // reference state, built from the requirements
  logic        m_mark = 1'b1;
  logic [22:0] m_hist = '1;
  logic        m_enc  = 1'b0;

  always #10 clk = ~clk;

  line_tx_framer #(.DIV_HI(2), .DIV_LO(4)) uut (
    .clk(clk), .rst_n(rst_n), .rate_hi(rate_hi), .master(master),
    .prescr_en(prescr_en), .b_data(b_data), .d_bits(d_bits), .hk(hk),
    .sym_out(sym_out), .sym_stb(sym_stb), .frame_start(frame_start)
  );

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {fs,sym}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic push_frame(logic hi, logic ms, logic pe, logic [15:0] b,
                            logic [1:0] d, logic h, string req);
    logic [19:0] bits;
    logic [6:0]  lf = 7'h7F;
    int n = hi ? 20 : 10;
    if (hi) bits = {m_mark, b, d[0], d[1], h};
    else    bits = {m_mark, b[7:0], d[0], 10'b0};
    for (int i = 0; i < n; i++) begin
      logic x, s;
      x = bits[19 - i];
      if (i != 0) begin
        x  = x ^ (pe & lf[6]);
        lf = {lf[5:0], lf[6] ^ lf[5]};
      end
      s = x ^ m_hist[22] ^ (ms ? m_hist[4] : m_hist[17]);
      m_hist = {m_hist[21:0], s};
      m_enc  = s ^ m_enc;
      exp_q.push_back({(i == 0), m_enc});
      tag_q.push_back(req);
      exp_q.push_back({1'b0, ~m_enc});
      tag_q.push_back(req);
    end
    m_mark = ~m_mark;
  endtask

  task automatic apply(logic hi, logic ms, logic pe, logic [15:0] b,
                       logic [1:0] d, logic h, string req);
    rate_hi = hi; master = ms; prescr_en = pe; b_data = b; d_bits = d; hk = h;
    push_frame(hi, ms, pe, b, d, h, req);
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!(sym_stb && frame_start));
  endtask

  task automatic wait_syms(int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!sym_stb);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && sym_stb && exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {frame_start, sym_out}, e);
    end
  end

  // driver
  initial begin
    apply(1'b0, 1'b1, 1'b0, 16'h00A5, 2'b01, 1'b0, "R1 R2 R3 R5 R7 R8 R9");
    repeat (3) @(negedge clk);
    check("R1 reset", {sym_stb, frame_start}, 2'b00);
    check("R1 reset sym", {1'b0, sym_out}, 2'b00);
    rst_n = 1'b1;
    wait_fs();
    apply(1'b0, 1'b1, 1'b1, 16'h0000, 2'b00, 1'b0, "R4 prescr zeros");
    wait_fs();
    apply(1'b0, 1'b0, 1'b0, 16'h00FF, 2'b01, 1'b0, "R6 slave");
    wait_fs();
    apply(1'b1, 1'b1, 1'b1, 16'h1234, 2'b10, 1'b1, "R1 R2 R4 high rate");
    wait_fs();
    apply(1'b1, 1'b0, 1'b1, 16'h8001, 2'b01, 1'b0, "R6 R2 high rate");
    wait_fs();
    apply(1'b1, 1'b1, 1'b0, 16'h0000, 2'b00, 1'b0, "R3 R5 marker only");
    wait_fs();
    // R10: junk mid-frame, then the real next-frame values
    rate_hi = 1'b0; master = 1'b0; prescr_en = 1'b1; b_data = 16'hFFFF;
    d_bits = 2'b11; hk = 1'b1;
    wait_syms(6);
    apply(1'b0, 1'b0, 1'b1, 16'h003C, 2'b00, 1'b0, "R10 mid-frame change");
    wait_fs();
    rate_hi = 1'b1; b_data = 16'h5555;
    wait_syms(9);
    apply(1'b1, 1'b1, 1'b1, 16'hC3A9, 2'b11, 1'b1, "R10 R11 rate switch");
    for (int k = 0; k < 8; k++) begin
      wait_fs();
      apply(logic'(k[0]), logic'(k[1]), logic'(k[2]), 16'(k * 16'h2F1D + 16'h0B7),
            2'(k), logic'(k % 3 == 0), "R3 R4 R5 R6 R8 sweep");
    end
    wait_fs();
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11: watchdog expired, actual pending=%0d expected 0", exp_q.size());
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule